// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block collects single-cycle event pulses from nine sources inside a peripheral and turns them into one level-sensitive interrupt line. Each source has a sticky pending bit. A pending bit stays set until software writes a 1 to it in the pending register. A separate mask decides which pending bits may drive the interrupt line. Software changes the mask only through two write-only ports: an unmask port and a mask port. A write of 1 to a bit in either port changes that bit and leaves every other bit alone, so two software contexts never need a read-modify-write to change the mask.

All four register views use one bit layout. The layout has ten positions, and position 8 is a permanent hole. Software can read the pending register and the current mask over a simple register bus. The block also raises a flag that is not masked. This flag shows that at least one pending bit belongs to the error group.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, every mask bit is 0 (the source is blocked), and both `irqOut` and `errAny` are 0.
- R2: A pulse on `evtPulse[i]` sets pending bit i at the next clock edge. The bit stays set until it is cleared. The positions are: 0 transfer done, 1 data threshold, 2 no-acknowledge, 3 timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to offset 0x10 (pending register) clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value. Writing back the value just read therefore clears exactly the bits that were set.
- R4: If an event pulse arrives in the same cycle as a clear of that same bit, the pending bit is 1 after the edge.
- R5: A write to offset 0x24 (unmask port) sets every mask bit whose write-data bit is 1. Zero bits have no effect.
- R6: A write to offset 0x28 (mask port) clears every mask bit whose write-data bit is 1. Zero bits have no effect.
- R7: The mask reads back at offset 0x20 and the pending register reads back at 0x10. Reads of 0x24, 0x28 and any other offset return 0.
- R8: `irqOut` is a register. It goes high one clock edge after at least one pending bit is set while its mask bit is 1. It goes low one edge after no such bit remains.
- R9: Position 8 never reads as 1 in the pending register or the mask, whatever the event input or the write data.
- R10: `errAny` is a register that is high one edge after any pending bit in the error group {2, 5, 6, 7, 9} is set. The mask does not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtPulse | input | 10 | One-cycle event pulses, one bit per source position |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | 8 | Byte offset of the register being accessed |
| busWdata | input | 10 | Write data, using the shared bit layout |
| busRdata | output | 10 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Registered interrupt line |
| errAny | output | 1 | Registered flag: a pending bit in the error group is set |

## Verification
The assertions assume that a write lasts exactly one cycle with a stable offset and stable data. They also assume that events are sampled only at clock edges, so each cycle is either one bus write or no write, possibly combined with event pulses. The stimulus drives every input on the falling edge and releases it one cycle later. The bench never starts a second write before the first one has been sampled. Reads are done only in idle cycles, so the readback value always matches the state that the assertions track.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic clrPend;   // write-1-to-clear on pending bits
    logic setMask;   // unmask bits written as 1
    logic clrMask;   // mask bits written as 1
  } strobe_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEND = 2'd1,
    RD_MASK = 2'd2
  } rdSel_t;

endpackage

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_PEND   = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_UNMASK = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_BLOCK  = 8'h28
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobes,
  output rdSel_t            rdSel
);

  logic hitPend;
  logic hitMask;
  logic hitUnmask;
  logic hitBlock;

  always_comb begin
    hitPend   = (busAddr == OFS_PEND);
    hitMask   = (busAddr == OFS_MASK);
    hitUnmask = (busAddr == OFS_UNMASK);
    hitBlock  = (busAddr == OFS_BLOCK);
  end

  // Write decode: one strobe per write-side view
  always_comb begin
    strobes.clrPend = busWe && hitPend;
    strobes.setMask = busWe && hitUnmask;
    strobes.clrMask = busWe && hitBlock;
  end

  // Read decode: the write-only ports fall into RD_NONE
  always_comb begin
    if (hitPend)      rdSel = RD_PEND;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_NONE;
  end

endmodule

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int NUM_POS = 10,
  parameter logic [NUM_POS-1:0] POS_USED  = 10'h2FF,
  parameter logic [NUM_POS-1:0] ERR_GROUP = 10'h2E4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_POS-1:0] evtPulse,
  input  logic [NUM_POS-1:0] wdata,
  input  strobe_t            strobes,
  input  rdSel_t             rdSel,
  output logic [NUM_POS-1:0] rdata,
  output logic [NUM_POS-1:0] pendVec,
  output logic [NUM_POS-1:0] maskVec,
  output logic               irqOut,
  output logic               errAny
);

  localparam logic [NUM_POS-1:0] ZERO_VEC = '0;

  logic [NUM_POS-1:0] pendQ, pendD;
  logic [NUM_POS-1:0] maskQ, maskD;
  logic [NUM_POS-1:0] clrVec, setVec, blkVec;
  logic               irqQ, errQ;

  always_comb begin
    clrVec = strobes.clrPend ? wdata : ZERO_VEC;
    setVec = strobes.setMask ? wdata : ZERO_VEC;
    blkVec = strobes.clrMask ? wdata : ZERO_VEC;
  end

  // An event wins over a clear of the same bit in the same cycle
  always_comb begin
    pendD = (evtPulse | (pendQ & ~clrVec)) & POS_USED;
    maskD = ((maskQ | setVec) & ~blkVec) & POS_USED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      irqQ  <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      pendQ <= pendD;
      maskQ <= maskD;
      irqQ  <= |(pendQ & maskQ);
      errQ  <= |(pendQ & ERR_GROUP);
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_PEND: rdata = pendQ;
      RD_MASK: rdata = maskQ;
      default: rdata = ZERO_VEC;
    endcase
  end

  assign pendVec = pendQ;
  assign maskVec = maskQ;
  assign irqOut  = irqQ;
  assign errAny  = errQ;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int NUM_POS = 10,
  parameter int ADDR_W  = 8,
  parameter logic [NUM_POS-1:0] POS_USED  = 10'h2FF,
  parameter logic [NUM_POS-1:0] ERR_GROUP = 10'h2E4,
  parameter logic [ADDR_W-1:0] OFS_PEND   = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h20,
  parameter logic [ADDR_W-1:0] OFS_UNMASK = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_BLOCK  = 8'h28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_POS-1:0] evtPulse,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_POS-1:0] busWdata,
  output logic [NUM_POS-1:0] busRdata,
  output logic               irqOut,
  output logic               errAny
);

  strobe_t            strobes;
  rdSel_t             rdSel;
  logic [NUM_POS-1:0] pendVec;
  logic [NUM_POS-1:0] maskVec;

  evt_irq_ctl #(
    .ADDR_W(ADDR_W), .OFS_PEND(OFS_PEND), .OFS_MASK(OFS_MASK),
    .OFS_UNMASK(OFS_UNMASK), .OFS_BLOCK(OFS_BLOCK)
  ) u_ctl (
    .busWe(busWe), .busAddr(busAddr), .strobes(strobes), .rdSel(rdSel)
  );

  evt_irq_dp #(
    .NUM_POS(NUM_POS), .POS_USED(POS_USED), .ERR_GROUP(ERR_GROUP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wdata(busWdata),
    .strobes(strobes), .rdSel(rdSel), .rdata(busRdata),
    .pendVec(pendVec), .maskVec(maskVec), .irqOut(irqOut), .errAny(errAny)
  );

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
  parameter int NUM_POS = 10,
  parameter int ADDR_W  = 8,
  parameter logic [NUM_POS-1:0] POS_USED  = 10'h2FF,
  parameter logic [NUM_POS-1:0] ERR_GROUP = 10'h2E4,
  parameter logic [ADDR_W-1:0] OFS_PEND   = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_UNMASK = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_BLOCK  = 8'h28
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_POS-1:0] evtPulse,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [NUM_POS-1:0] busWdata,
  input logic [NUM_POS-1:0] pendVec,
  input logic [NUM_POS-1:0] maskVec,
  input logic               irqOut,
  input logic               errAny
);

  logic wrPend, wrMaskPorts, wrUnmask, wrBlock;
  assign wrPend      = busWe && (busAddr == OFS_PEND);
  assign wrUnmask    = busWe && (busAddr == OFS_UNMASK);
  assign wrBlock     = busWe && (busAddr == OFS_BLOCK);
  assign wrMaskPorts = wrUnmask || wrBlock;

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtPulse & POS_USED)) |=> ((pendVec & $past(evtPulse & POS_USED)) == $past(evtPulse & POS_USED))); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrPend |=> ((pendVec & $past(pendVec)) == $past(pendVec))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrPend |=> ((pendVec & $past(busWdata & ~evtPulse)) == '0)); // R3
  AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (!rstN)
    wrUnmask |=> ((maskVec & $past(busWdata & POS_USED)) == $past(busWdata & POS_USED))); // R5
  AST_BLOCK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrBlock |=> ((maskVec & $past(busWdata)) == '0)); // R6
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrMaskPorts |=> $stable(maskVec)); // R5
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(pendVec & maskVec)))); // R8
  AST_ERR_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (errAny == $past(|(pendVec & ERR_GROUP)))); // R10
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec | maskVec) & ~POS_USED) == '0); // R9

endmodule

bind evt_irq_ctrl evt_irq_chk #(
  .NUM_POS(NUM_POS), .ADDR_W(ADDR_W), .POS_USED(POS_USED), .ERR_GROUP(ERR_GROUP),
  .OFS_PEND(OFS_PEND), .OFS_UNMASK(OFS_UNMASK), .OFS_BLOCK(OFS_BLOCK)
) u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .pendVec(pendVec), .maskVec(maskVec),
  .irqOut(irqOut), .errAny(errAny)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;

  localparam logic [7:0] A_PEND = 8'h10;
  localparam logic [7:0] A_MASK = 8'h20;
  localparam logic [7:0] A_UNM  = 8'h24;
  localparam logic [7:0] A_BLK  = 8'h28;
  localparam logic [1:0] OP_NONE = 2'd0, OP_CLR = 2'd1, OP_UNM = 2'd2, OP_BLK = 2'd3;

  // {evt, op, wdata, expPend, expMask, expIrq, expErr}
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {10'h001, OP_NONE, 10'h000, 10'h001, 10'h000, 1'b0, 1'b0},
    {10'h000, OP_UNM,  10'h001, 10'h001, 10'h001, 1'b1, 1'b0},
    {10'h204, OP_NONE, 10'h000, 10'h205, 10'h001, 1'b1, 1'b1},
    {10'h000, OP_CLR,  10'h001, 10'h204, 10'h001, 1'b0, 1'b1},
    {10'h000, OP_UNM,  10'h200, 10'h204, 10'h201, 1'b1, 1'b1},
    {10'h000, OP_BLK,  10'h001, 10'h204, 10'h200, 1'b1, 1'b1},
    {10'h200, OP_CLR,  10'h204, 10'h200, 10'h200, 1'b1, 1'b1},
    {10'h000, OP_CLR,  10'h200, 10'h000, 10'h200, 1'b0, 1'b0},
    {10'h100, OP_NONE, 10'h000, 10'h000, 10'h200, 1'b0, 1'b0},
    {10'h000, OP_UNM,  10'h3FF, 10'h000, 10'h2FF, 1'b0, 1'b0},
    {10'h0F2, OP_NONE, 10'h000, 10'h0F2, 10'h2FF, 1'b1, 1'b1},
    {10'h000, OP_BLK,  10'h0F2, 10'h0F2, 10'h20D, 1'b0, 1'b1},
    {10'h000, OP_CLR,  10'h0F0, 10'h002, 10'h20D, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] evtPulse = '0;
  logic       busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [9:0] busWdata = '0;
  logic [9:0] busRdata;
  logic       irqOut, errAny;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .errAny(errAny)
  );

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [9:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  // Drive one cycle of stimulus at a falling edge, then release it
  task automatic drive(input logic [9:0] evt, input logic [1:0] op, input logic [9:0] wd);
    @(negedge clk);
    evtPulse = evt;
    busWdata = wd;
    busWe    = (op != OP_NONE);
    case (op)
      OP_CLR:  busAddr = A_PEND;
      OP_UNM:  busAddr = A_UNM;
      OP_BLK:  busAddr = A_BLK;
      default: busAddr = 8'h00;
    endcase
    @(negedge clk);
    evtPulse = '0;
    busWe    = 1'b0;
    busWdata = '0;
  endtask

  initial begin
    logic [9:0] rd;
    repeat (3) @(negedge clk);
    readReg(A_PEND, rd); chk("R1 pending after reset", rd, 10'h000);
    readReg(A_MASK, rd); chk("R1 mask after reset", rd, 10'h000);
    chk("R1 irq after reset", {9'd0, irqOut}, 10'h000);
    chk("R1 err after reset", {9'd0, errAny}, 10'h000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][43:34], VEC[i][33:32], VEC[i][31:22]);
      @(negedge clk);
      readReg(A_PEND, rd); chk($sformatf("R2/R3/R4/R9 pending vec %0d", i), rd, VEC[i][21:12]);
      readReg(A_MASK, rd); chk($sformatf("R5/R6/R7/R9 mask vec %0d", i), rd, VEC[i][11:2]);
      chk($sformatf("R8 irq vec %0d", i), {9'd0, irqOut}, {9'd0, VEC[i][1]});
      chk($sformatf("R10 err vec %0d", i), {9'd0, errAny}, {9'd0, VEC[i][0]});
    end

    // R7: write-only ports and unmapped offsets read as zero
    readReg(A_UNM, rd); chk("R7 unmask port reads zero", rd, 10'h000);
    readReg(A_BLK, rd); chk("R7 mask port reads zero", rd, 10'h000);
    readReg(8'h14, rd); chk("R7 unmapped offset reads zero", rd, 10'h000);

    // R8: exact latency. State: pending=002, mask=20D
    drive(10'h008, OP_NONE, 10'h000);
    readReg(A_PEND, rd); chk("R2 timeout bit set one edge later", rd, 10'h00A);
    chk("R8 irq still low before its register", {9'd0, irqOut}, 10'h000);
    @(negedge clk);
    chk("R8 irq high one edge after pending", {9'd0, irqOut}, 10'h001);
    chk("R10 err ignores non-error bits", {9'd0, errAny}, 10'h000);

    // R9: event on the hole position leaves pending unchanged
    drive(10'h100, OP_UNM, 10'h100);
    readReg(A_PEND, rd); chk("R9 hole event ignored", rd, 10'h00A);
    readReg(A_MASK, rd); chk("R9 hole unmask ignored", rd, 10'h20D);

    // R3: writing back the read value clears exactly those bits
    readReg(A_PEND, rd);
    drive(10'h000, OP_CLR, rd);
    readReg(A_PEND, rd); chk("R3 read-back write clears all", rd, 10'h000);
    @(negedge clk);
    chk("R8 irq low after clear", {9'd0, irqOut}, 10'h000);

    // R1: mid-run reset
    drive(10'h204, OP_NONE, 10'h000);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    readReg(A_PEND, rd); chk("R1 pending cleared by reset", rd, 10'h000);
    readReg(A_MASK, rd); chk("R1 mask cleared by reset", rd, 10'h000);
    chk("R1 irq cleared by reset", {9'd0, irqOut}, 10'h000);
    chk("R1 err cleared by reset", {9'd0, errAny}, 10'h000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule